// File: doc/BRIEF.md
# Ring Port Bypass Router

This block routes a bit-serial arbitrated loop through five drive slots of a disk enclosure. Every slot, called a cell, has a serial line toward its drive, a serial line back from its drive, and an active-low bypass control. Each cell holds one 2:1 selector. The selector either takes the data coming back from its own drive, or passes on the value it received from the stage before it. Chained together, the five selectors form a closed ring: 0, 1, 2, 3, 4 and back to 0.

A single retiming flip-flop sits between cell 0 and cell 1. It models the clock-recovery stage, and it also breaks the combinational ring when every cell is bypassed. The cable may be attached at any cell. Its position sets how many drives lie upstream of the retiming point:

| Cable cell | Retiming point |
|---|---|
| 0 | before the first drive |
| 4 | after the first drive |
| 3 | after the second drive |
| 2 | after the third drive |
| 1 | after the last drive |

Bypass controls pass through a reset-cleared synchronizer before they steer any selector. A signal-valid indication for cell 0 is registered onto a status output.

Top module: `ring_bypass_router`

## Requirements
- R1: While `rst` is high at a clock edge, the retiming flop, the status output and all synchronized controls clear to 0. Every cell then counts as bypassed, so every `nodeOut` bit reads 0 whatever `nodeIn` carries.
- R2: When cell k (1..3) is in the loop, `nodeOut[k+1]` equals `nodeIn[k]` in the same cycle. In-loop means `bypassN[k]`=1 after synchronization.
- R3: When cell k (1..3) is bypassed, `nodeOut[k+1]` carries whatever cell k received from upstream. For k=1 this is the retiming flop. For k>1 it is the selector result of cell k-1. Cell k is bypassed when `bypassN[k]`=0 after synchronization.
- R4: `nodeOut[1]` is the retiming flop. It presents, one clock later, the cell-0 selector result: `nodeIn[0]` when cell 0 is in the loop, otherwise the cell-4 selector result.
- R5: `nodeOut[0]` is the cell-4 selector result, produced combinationally. When cell 4 is in the loop it equals `nodeIn[4]`.
- R6: A change on `bypassN` first steers the selectors after exactly two rising clock edges. After one edge the old routing still holds.
- R7: With all five cells bypassed, the retiming flop recirculates its value. All five `nodeOut` bits equal that held value, and it stays stable whatever `nodeIn` does.
- R8: `sigDetect` equals `sigValid` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| nodeIn | input | 5 | Serial data returning from the drive at each cell |
| bypassN | input | 5 | Per-cell bypass control; 0 skips the drive, 1 keeps it in the loop |
| sigValid | input | 1 | Signal-present indication for the cell-0 input |
| nodeOut | output | 5 | Serial data toward the drive (or cable) at each cell |
| sigDetect | output | 1 | Registered cell-0 signal-present status |

## Verification
The assertions assume that reset is held for at least one edge before any check begins. The sync-latency and status checks also assume at least two clean edges after reset, and a counter enforces this. No assumption is made about how `bypassN` or `nodeIn` toggle. The stimulus therefore changes data, controls and `sigValid` freely every cycle, from a single point away from the clock edge. It sweeps all 32 bypass patterns with random serial data, and a bench model of the synchronizer and the retiming flop covers the cycles in which a pattern changes.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
  localparam int RING_CELLS = 5;
  localparam int RETIME_CELL = 0;

  typedef logic [RING_CELLS-1:0] cellVec_t;

  typedef struct packed {
    cellVec_t keep;
    logic     detect;
  } strobes_t;
endpackage

// File: rtl/rbr_ctrl.sv
module rbr_ctrl
  import rbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  cellVec_t bypassN,
  input  logic     sigValid,
  output strobes_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  cellVec_t syncQ [SYNC_STAGES];
  logic     detectQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      detectQ <= 1'b0;
    end else begin
      syncQ[0] <= bypassN;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      detectQ <= sigValid;
    end
  end

  assign strobes.keep   = syncQ[LAST];
  assign strobes.detect = detectQ;

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_lat2
      a_r6_sync_latency: assert property (@(posedge clk) disable iff (rst)
        (sinceRst >= 2'd2) |-> (strobes.keep == $past(bypassN, 2)));
    end
  endgenerate

  a_r8_detect_delay: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd1) |-> (strobes.detect == $past(sigValid)));
endmodule

// File: rtl/rbr_datapath.sv
module rbr_datapath
  import rbr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  cellVec_t nodeIn,
  input  strobes_t strobes,
  output cellVec_t nodeOut,
  output logic     sigDetect
);
  localparam int N = RING_CELLS;

  logic     retimeQ;
  logic     entrySel;
  cellVec_t ringOut;

  always_comb begin
    logic carry;
    carry = retimeQ;
    ringOut = '0;
    ringOut[(RETIME_CELL + 1) % N] = retimeQ;
    for (int i = 1; i < N; i++) begin
      carry = strobes.keep[i] ? nodeIn[i] : carry;
      ringOut[(i + 1) % N] = carry;
    end
    entrySel = strobes.keep[0] ? nodeIn[0] : carry;
  end

  always_ff @(posedge clk) begin
    if (rst) retimeQ <= 1'b0;
    else     retimeQ <= entrySel;
  end

  assign nodeOut   = ringOut;
  assign sigDetect = strobes.detect;

  generate
    for (genvar k = 1; k < N - 1; k++) begin : g_inloop
      a_r2_keep_passes_own: assert property (@(posedge clk) disable iff (rst)
        strobes.keep[k] |-> (nodeOut[k+1] == nodeIn[k]));
    end
  endgenerate

  a_r5_last_to_zero: assert property (@(posedge clk) disable iff (rst)
    strobes.keep[N-1] |-> (nodeOut[0] == nodeIn[N-1]));

  a_r4_retime_delay: assert property (@(posedge clk) disable iff (rst)
    strobes.keep[0] |=> (nodeOut[1] == $past(nodeIn[0])));

  a_r7_all_bypass_equal: assert property (@(posedge clk) disable iff (rst)
    (strobes.keep == '0) |-> (nodeOut == {N{nodeOut[1]}}));

  a_r7_all_bypass_hold: assert property (@(posedge clk) disable iff (rst)
    (strobes.keep == '0) |=> $stable(nodeOut[1]));
endmodule

// File: rtl/ring_bypass_router.sv
module ring_bypass_router
  import rbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RING_CELLS-1:0] nodeIn,
  input  logic [RING_CELLS-1:0] bypassN,
  input  logic                  sigValid,
  output logic [RING_CELLS-1:0] nodeOut,
  output logic                  sigDetect
);
  strobes_t strobes;

  rbr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bypassN  (bypassN),
    .sigValid (sigValid),
    .strobes  (strobes)
  );

  rbr_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .nodeIn    (nodeIn),
    .strobes   (strobes),
    .nodeOut   (nodeOut),
    .sigDetect (sigDetect)
  );
endmodule

// File: tb/sim_ring_bypass_router.sv
module sim_ring_bypass_router;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] nodeIn;
  logic [4:0] bypassN;
  logic       sigValid;
  logic [4:0] nodeOut;
  logic       sigDetect;

  int checkCount = 0;
  int failCount  = 0;

  logic [4:0] mS1   = '0;
  logic [4:0] mKeep = '0;
  logic       mR    = 1'b0;
  logic       mDet  = 1'b0;

  always #2.5 clk = ~clk;

  ring_bypass_router u0 (
    .clk(clk), .rst(rst), .nodeIn(nodeIn), .bypassN(bypassN),
    .sigValid(sigValid), .nodeOut(nodeOut), .sigDetect(sigDetect)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [4:0] din, input logic [4:0] byp,
                      input logic sv, input logic r);
    logic [4:0] expOut;
    logic carry;
    logic sel0;
    @(negedge clk);
    nodeIn = din; bypassN = byp; sigValid = sv; rst = r;
    #1;
    carry = mR;
    expOut = '0;
    expOut[1] = mR;
    for (int i = 1; i < 5; i++) begin
      carry = mKeep[i] ? din[i] : carry;
      expOut[(i + 1) % 5] = carry;
    end
    sel0 = mKeep[0] ? din[0] : carry;
    if (!r) begin
      chk("R4 nodeOut[1]", {31'd0, nodeOut[1]}, {31'd0, expOut[1]});
      chk("R5 nodeOut[0]", {31'd0, nodeOut[0]}, {31'd0, expOut[0]});
      for (int k = 2; k < 5; k++) begin
        if (mKeep[k-1]) chk("R2 nodeOut[k]", {31'd0, nodeOut[k]}, {31'd0, expOut[k]});
        else            chk("R3 nodeOut[k]", {31'd0, nodeOut[k]}, {31'd0, expOut[k]});
      end
      chk("R8 sigDetect", {31'd0, sigDetect}, {31'd0, mDet});
    end
    if (r) begin
      mR = 1'b0; mKeep = '0; mS1 = '0; mDet = 1'b0;
    end else begin
      mR = sel0; mKeep = mS1; mS1 = byp; mDet = sv;
    end
  endtask

  initial begin
    #1_000_000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    rst = 1'b1; nodeIn = 5'h1F; bypassN = 5'h1F; sigValid = 1'b1;
    step(5'h1F, 5'h1F, 1'b1, 1'b1);
    step(5'h1F, 5'h1F, 1'b1, 1'b1);
    // R1: reset clears everything; all cells count as bypassed
    chk("R1 nodeOut in reset", {27'd0, nodeOut}, 32'd0);
    chk("R1 sigDetect in reset", {31'd0, sigDetect}, 32'd0);

    // R6: routing change lands after two edges
    for (int c = 0; c < 3; c++) step(5'b00100, 5'h1F, 1'b0, 1'b0);
    step(5'b00100, 5'b11011, 1'b0, 1'b0);
    chk("R6 before first edge", {31'd0, nodeOut[3]}, 32'd1);
    step(5'b00100, 5'b11011, 1'b0, 1'b0);
    chk("R6 after one edge", {31'd0, nodeOut[3]}, 32'd1);
    step(5'b00100, 5'b11011, 1'b0, 1'b0);
    chk("R6 after two edges", {31'd0, nodeOut[3]}, 32'd0);

    // R7: load a 1 into the retime flop, then bypass everything
    for (int c = 0; c < 3; c++) step(5'h01, 5'h1F, 1'b1, 1'b0);
    for (int c = 0; c < 3; c++) step(5'h01, 5'h00, 1'b1, 1'b0);
    for (int c = 0; c < 10; c++) begin
      step(5'($urandom), 5'h00, 1'($urandom), 1'b0);
      chk("R7 all bypassed hold", {27'd0, nodeOut}, 32'h1F);
    end

    // Full sweep of all bypass patterns with random serial data
    for (int pat = 0; pat < 32; pat++) begin
      for (int c = 0; c < 8; c++) step(5'($urandom), 5'(pat), 1'($urandom), 1'b0);
    end
    for (int pat = 31; pat >= 0; pat--) begin
      for (int c = 0; c < 4; c++) step(5'($urandom), 5'(pat), 1'($urandom), 1'b0);
    end

    // R1: reset in the middle of traffic
    step(5'h1F, 5'h1F, 1'b1, 1'b1);
    step(5'h1F, 5'h1F, 1'b1, 1'b1);
    chk("R1 nodeOut after mid reset", {27'd0, nodeOut}, 32'd0);
    for (int c = 0; c < 6; c++) step(5'($urandom), 5'($urandom), 1'($urandom), 1'b0);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule